// File: doc/BRIEF.md
# Programmable Frame Rate Generator

This block derives the timing of a multiplexed LCD drive from one base clock. The base clock is delivered as a one-cycle enable pulse `base_en` on the system clock. It comes either from an internal oscillator near 300 kHz or from an external source running at 300 kHz or 38 kHz. A 3-bit rate code and the clock-source selection together set the frame period. The frame is split into equal common steps, three or four depending on the duty. The block emits one `step_tick` per step for the drive sequencer, plus a `frame_par` bit that flips once per frame.

Port pin 1 is either a static general-purpose level or a divided copy of the base clock. In power-saving mode and while inhibit is active, the base clock is treated as stopped. Any change of configuration restarts all dividers from zero, so the sequencer and the port never see a shortened step or a runt clock pulse.

Top module: `frame_rate_gen`

## Requirements
- R1: With the 300 kHz divider set and four-step duty (`quad_duty`=1), consecutive `step_tick` pulses are frame/4 base ticks apart. The frame for rate codes 0 to 6 is 6144, 4608, 3072, 2304, 1536, 1152 and 768 base ticks.
- R2: With three-step duty (`quad_duty`=0), the step spacing is frame/3 base ticks.
- R3: When `ext_sel`=1 and `ext_low`=1, the frame for codes 0 to 6 is 768, 576, 384, 288, 192, 144 and 96 base ticks. Spacing scales with the `base_en` rate.
- R4: `ext_low` has no effect while `ext_sel`=0; the 300 kHz set applies.
- R5: Rate code 7 gives the same frame as rate code 2, in both divider sets.
- R6: `frame_par` is 0 after a restart and flips together with every step tick that ends a frame, that is, every 3rd or 4th tick. It never changes except on such a tick or when cleared.
- R7: `p1_mode`=2'b01 drives `p1_out` at base/2, and `p1_mode`=2'b10 drives it at base/8 (rising edges 2 and 8 base ticks apart).
- R8: `p1_mode`=2'b00 or 2'b11 drives `p1_out` with the registered value of `p1_gpo`.
- R9: While `power_save`=1 (and `inhibit_n`=1), no step ticks occur and `p1_out` holds the `p1_gpo` level even in a clock mode.
- R10: While `inhibit_n`=0, no step ticks occur and `p1_out` is 0.
- R11: A change of rate code, source, frequency, duty or port mode restarts the dividers. With `base_en` held high, the first tick comes slot+1 cycles after the input change, and no tick occurs in the cycle after the change.
- R12: During and right after reset, `step_tick`, `frame_par` and `p1_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_en | input | 1 | One pulse per base-clock period |
| inhibit_n | input | 1 | Low forces display off and stops the base clock |
| power_save | input | 1 | High stops the base clock |
| ext_sel | input | 1 | 1 selects external clock source |
| ext_low | input | 1 | 1 selects the 38 kHz external frequency |
| quad_duty | input | 1 | 1 for four steps per frame, 0 for three |
| rate_code | input | 3 | Frame-rate code |
| p1_mode | input | 2 | Port-1 function: 01 base/2, 10 base/8, else static |
| p1_gpo | input | 1 | Static level for port 1 |
| step_tick | output | 1 | One-cycle pulse per common step |
| frame_par | output | 1 | Toggles once per frame |
| p1_out | output | 1 | Port-1 output |

## Verification
The properties assume that configuration inputs change only between clock edges and stay legal two-valued signals. They also assume `base_en` is a plain enable that may arrive at any rate. The stimulus changes configuration only just after a rising edge, and every new setting differs from the previous one so that each test begins with a restart. `base_en` is held high, except in one half-rate run that checks scaling. This keeps the expected spacing an exact cycle count.

// File: rtl/frg_pkg.sv
package frg_pkg;

    typedef struct packed {
        logic [2:0] code;
        logic       ext_sel;
        logic       ext_low;
        logic       quad;
        logic [1:0] p1_mode;
    } frg_cfg_t;

    // Frame length in units: frame = mult * unit
    function automatic logic [5:0] frame_mult(input logic [2:0] code);
        case (code)
            3'd0:    frame_mult = 6'd48;
            3'd1:    frame_mult = 6'd36;
            3'd2:    frame_mult = 6'd24;
            3'd3:    frame_mult = 6'd18;
            3'd4:    frame_mult = 6'd12;
            3'd5:    frame_mult = 6'd9;
            3'd6:    frame_mult = 6'd6;
            default: frame_mult = 6'd24;   // reserved code aliases code 2
        endcase
    endfunction

    // One third of frame_mult (all multipliers are divisible by 3)
    function automatic logic [4:0] third_mult(input logic [2:0] code);
        case (code)
            3'd0:    third_mult = 5'd16;
            3'd1:    third_mult = 5'd12;
            3'd2:    third_mult = 5'd8;
            3'd3:    third_mult = 5'd6;
            3'd4:    third_mult = 5'd4;
            3'd5:    third_mult = 5'd3;
            3'd6:    third_mult = 5'd2;
            default: third_mult = 5'd8;
        endcase
    endfunction

endpackage

// File: rtl/frg_div_sel.sv
module frg_div_sel
    import frg_pkg::*;
#(
    parameter int UNIT_STD = 128,
    parameter int UNIT_LOW = 16,
    parameter int CNT_W    = 12
) (
    input  logic [2:0]       code,
    input  logic             ext_sel,
    input  logic             ext_low,
    input  logic             quad,
    output logic [CNT_W-1:0] slot_len
);
    localparam int PW = CNT_W + 8;

    logic [PW-1:0] unit;
    logic [PW-1:0] prod;

    always_comb begin
        unit = (ext_sel && ext_low) ? PW'(UNIT_LOW) : PW'(UNIT_STD);
        if (quad) begin
            prod = (PW'(frame_mult(code)) * unit) >> 2;
        end else begin
            prod = PW'(third_mult(code)) * unit;
        end
        slot_len = prod[CNT_W-1:0];
    end
endmodule

// File: rtl/frg_slot_ctr.sv
module frg_slot_ctr #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             base_en,
    input  logic             quad,
    input  logic [CNT_W-1:0] slot_len,
    output logic             step_tick,
    output logic             frame_par
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [1:0]       slot;
        logic             par;
        logic             tick;
    } st_t;

    st_t st_d, st_q;
    logic [1:0] last_slot;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        last_slot = quad ? 2'd3 : 2'd2;
        if (!run || restart) begin
            st_d.cnt  = '0;
            st_d.slot = '0;
            st_d.par  = 1'b0;
        end else if (base_en) begin
            if (st_q.cnt == slot_len - 1'b1) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
                if (st_q.slot >= last_slot) begin
                    st_d.slot = '0;
                    st_d.par  = ~st_q.par;
                end else begin
                    st_d.slot = st_q.slot + 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign step_tick = st_q.tick;
    assign frame_par = st_q.par;
endmodule

// File: rtl/frg_p1_clk.sv
module frg_p1_clk (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic       base_en,
    input  logic       inhibit_n,
    input  logic [1:0] mode,
    input  logic       gpo,
    output logic       p1_out
);
    typedef struct packed {
        logic [1:0] div;
        logic       tog;
        logic       out;
    } pc_t;

    pc_t pc_d, pc_q;
    logic clk_mode;

    always_comb begin
        pc_d     = pc_q;
        clk_mode = (mode == 2'b01) || (mode == 2'b10);
        if (!run || restart || !clk_mode) begin
            pc_d.div = '0;
            pc_d.tog = 1'b0;
        end else if (base_en) begin
            if (mode == 2'b01) begin
                pc_d.tog = ~pc_q.tog;
            end else if (pc_q.div == 2'd3) begin
                pc_d.div = '0;
                pc_d.tog = ~pc_q.tog;
            end else begin
                pc_d.div = pc_q.div + 1'b1;
            end
        end
        if (!inhibit_n)                 pc_d.out = 1'b0;
        else if (clk_mode && run)       pc_d.out = pc_d.tog;
        else                            pc_d.out = gpo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign p1_out = pc_q.out;
endmodule

// File: rtl/frame_rate_gen.sv
module frame_rate_gen
    import frg_pkg::*;
#(
    parameter int UNIT_STD = 128,
    parameter int UNIT_LOW = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       base_en,
    input  logic       inhibit_n,
    input  logic       power_save,
    input  logic       ext_sel,
    input  logic       ext_low,
    input  logic       quad_duty,
    input  logic [2:0] rate_code,
    input  logic [1:0] p1_mode,
    input  logic       p1_gpo,
    output logic       step_tick,
    output logic       frame_par,
    output logic       p1_out
);
    localparam int SLOT_MAX = 16 * UNIT_STD;
    localparam int CNT_W    = $clog2(SLOT_MAX + 1);

    frg_cfg_t cfg_now, cfg_d, cfg_q;
    logic restart, run;
    logic [CNT_W-1:0] slot_len;

    always_comb begin
        cfg_now = '{code: rate_code, ext_sel: ext_sel, ext_low: ext_low,
                    quad: quad_duty, p1_mode: p1_mode};
        cfg_d   = cfg_now;
        restart = (cfg_now != cfg_q);
        run     = inhibit_n && !power_save;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    frg_div_sel #(.UNIT_STD(UNIT_STD), .UNIT_LOW(UNIT_LOW), .CNT_W(CNT_W)) u_sel (
        .code(rate_code), .ext_sel(ext_sel), .ext_low(ext_low),
        .quad(quad_duty), .slot_len(slot_len)
    );

    frg_slot_ctr #(.CNT_W(CNT_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
        .base_en(base_en), .quad(quad_duty), .slot_len(slot_len),
        .step_tick(step_tick), .frame_par(frame_par)
    );

    frg_p1_clk u_p1 (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
        .base_en(base_en), .inhibit_n(inhibit_n), .mode(p1_mode),
        .gpo(p1_gpo), .p1_out(p1_out)
    );
endmodule

// File: rtl/frg_checker.sv
module frg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       base_en,
    input logic       inhibit_n,
    input logic       power_save,
    input logic       ext_sel,
    input logic       ext_low,
    input logic       quad_duty,
    input logic [2:0] rate_code,
    input logic [1:0] p1_mode,
    input logic       p1_gpo,
    input logic       step_tick,
    input logic       frame_par,
    input logic       p1_out
);
    // R1: steps are never back to back
    a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        step_tick |=> !step_tick);

    // R6: parity only flips on a step tick, or clears
    a_r6_par_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_par != $past(frame_par)) |-> (step_tick || !frame_par));

    // R8: static port levels follow the general-purpose input
    a_r8_static_level: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_n && (p1_mode == 2'b00 || p1_mode == 2'b11)) |=> (p1_out == $past(p1_gpo)));

    // R9: power saving stops steps and the port clock
    a_r9_save_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (power_save && inhibit_n) |=> (!step_tick && p1_out == $past(p1_gpo)));

    // R10: inhibit forces everything low
    a_r10_inhibit_low: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit_n |=> (!step_tick && !p1_out));

    // R11: a rate or duty change suppresses the next tick
    a_r11_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((rate_code != $past(rate_code)) || (quad_duty != $past(quad_duty))) |=> !step_tick);
endmodule

bind frame_rate_gen frg_checker u_chk (.*);

// File: tb/tb_frame_rate_gen.sv
module tb_frame_rate_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic base_en = 1'b1;
    logic inhibit_n = 1'b1;
    logic power_save = 1'b0;
    logic ext_sel = 1'b0;
    logic ext_low = 1'b0;
    logic quad_duty = 1'b1;
    logic [2:0] rate_code = 3'd0;
    logic [1:0] p1_mode = 2'b00;
    logic p1_gpo = 1'b0;
    logic step_tick, frame_par, p1_out;

    always #10 clk = ~clk;   // 50 MHz

    frame_rate_gen dut (
        .clk(clk), .rst_n(rst_n), .base_en(base_en), .inhibit_n(inhibit_n),
        .power_save(power_save), .ext_sel(ext_sel), .ext_low(ext_low),
        .quad_duty(quad_duty), .rate_code(rate_code), .p1_mode(p1_mode),
        .p1_gpo(p1_gpo), .step_tick(step_tick), .frame_par(frame_par),
        .p1_out(p1_out)
    );

    int drv_checks = 0, drv_fails = 0;
    int mon_checks = 0, mon_fails = 0;
    int gen = 0;
    int cur_duty = 0;
    bit half_rate = 1'b0;
    bit done = 1'b0;
    int    expq[$];
    string tagq[$];

    always @(posedge clk) base_en <= half_rate ? ~base_en : 1'b1;

    task automatic dcheck(input bit ok, input string req, input int act, input int exp);
        drv_checks++;
        if (!ok) begin
            drv_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard monitor: step spacing and frame parity
    initial begin
        int last_gen = 0, since = 0, nticks = 0, e;
        string t;
        forever begin
            @(negedge clk);
            since++;
            if (gen != last_gen) begin
                last_gen = gen; since = 0; nticks = 0;
                continue;
            end
            if (step_tick) begin
                nticks++;
                if (expq.size() > 0) begin
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    if (e >= 0) begin
                        mon_checks++;
                        if (since != e) begin
                            mon_fails++;
                            $display("FAIL %s spacing actual=%0d expected=%0d", t, since, e);
                        end
                    end
                end
                if (cur_duty > 0) begin
                    mon_checks++;
                    if (frame_par != 1'(((nticks / cur_duty) % 2))) begin
                        mon_fails++;
                        $display("FAIL R6 parity actual=%0d expected=%0d", frame_par,
                                 (nticks / cur_duty) % 2);
                    end
                end
                since = 0;
            end
        end
    end

    function automatic int exp_frame(input int code, input bit low);
        int c = (code == 7) ? 2 : code;
        int std[7] = '{6144, 4608, 3072, 2304, 1536, 1152, 768};
        return low ? std[c] / 8 : std[c];
    endfunction

    task automatic run_cfg(input int code, input bit ext, input bit low, input bit quad,
                           input bit half, input int ntk, input string tag);
        int len;
        @(posedge clk); #1;
        rate_code = 3'(code); ext_sel = ext; ext_low = low; quad_duty = quad;
        half_rate = half;
        cur_duty = quad ? 4 : 3;
        len = exp_frame(code, ext && low) / cur_duty;
        expq.push_back(half ? -1 : len + 1); tagq.push_back("R11");
        for (int i = 1; i < ntk; i++) begin
            expq.push_back(half ? 2 * len : len);
            tagq.push_back(tag);
        end
        gen++;
        while (expq.size() > 0) @(negedge clk);
    endtask

    task automatic p1_period(input int exp, input string req);
        int n = 0;
        repeat (4) @(negedge clk);
        while (p1_out) @(negedge clk);
        while (!p1_out) @(negedge clk);
        do begin @(negedge clk); n++; end while (p1_out);
        while (!p1_out) begin @(negedge clk); n++; end
        dcheck(n == exp, req, n, exp);
    endtask

    task automatic quiet_window(input bit exp_p1, input string req);
        int bad = 0;
        repeat (3) @(negedge clk);
        repeat (40) begin
            @(negedge clk);
            if (step_tick || p1_out != exp_p1) bad++;
        end
        dcheck(bad == 0, req, bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        dcheck(step_tick == 0 && frame_par == 0 && p1_out == 0, "R12", p1_out, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        dcheck(step_tick == 0 && frame_par == 0 && p1_out == 0, "R12", step_tick, 0);

        run_cfg(6, 0, 0, 1, 0, 6, "R1");   // 192
        run_cfg(4, 0, 0, 0, 0, 4, "R2");   // 512
        run_cfg(0, 1, 1, 0, 0, 4, "R3");   // 256
        run_cfg(5, 0, 1, 1, 0, 5, "R4");   // 288, low bit ignored
        run_cfg(7, 0, 0, 1, 0, 3, "R5");   // 768
        run_cfg(7, 1, 1, 0, 0, 4, "R5");   // 128
        run_cfg(6, 1, 1, 1, 1, 6, "R3");   // 24 at half rate -> 48
        run_cfg(1, 0, 0, 1, 0, 2, "R1");   // 1152

        cur_duty = 0;
        @(posedge clk); #1 p1_mode = 2'b01; gen++;
        p1_period(2, "R7");
        @(posedge clk); #1 p1_mode = 2'b10; gen++;
        p1_period(8, "R7");
        @(posedge clk); #1 p1_mode = 2'b11; p1_gpo = 1'b1; gen++;
        quiet_window(1'b1, "R8");
        @(posedge clk); #1 p1_mode = 2'b00; p1_gpo = 1'b0; gen++;
        quiet_window(1'b0, "R8");
        @(posedge clk); #1 p1_mode = 2'b01; p1_gpo = 1'b1; power_save = 1'b1; gen++;
        quiet_window(1'b1, "R9");
        @(posedge clk); #1 power_save = 1'b0; inhibit_n = 1'b0; gen++;
        quiet_window(1'b0, "R10");
        @(posedge clk); #1 inhibit_n = 1'b1; p1_mode = 2'b00;
        run_cfg(3, 1, 1, 1, 0, 5, "R3");   // 72

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", drv_checks + mon_checks, drv_fails + mon_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", drv_checks + mon_checks + 1,
                     drv_fails + mon_fails + 1);
            $finish;
        end
    end
endmodule